// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A 16-bit interval timer that counts down from a value written by software and signals each expiry with a level interrupt. The count rate is the input clock divided by a prescaler that is set in the control register. The same register picks the mode and enables counting. In periodic mode the timer reloads itself after each expiry, which gives a steady tick for an operating-system clock. In one-shot mode it stops at zero and turns itself off.

Software reaches the timer through a plain register port: a 2-bit word address, a write strobe, write data and combinational read data. The live count can be read at any time. Because the count falls steadily, software can find the time elapsed within an interval by subtracting the value read from the reload value. Any write to the clear address removes a pending interrupt.

Top module: `interval_timer`

## Requirements
- R1: A write to the reload address (0) whose data has any bit set above bit 15 is rejected. The reload register and the counter keep their old values.
- R2: A valid write to the reload address sets both the reload register and the counter to the written value on the next cycle. It also restarts the prescaler, so the next decrement comes one full prescale period after the write.
- R3: The control register (address 2) reads back its value as bit 0 = enable, bit 1 = mode (1 periodic, 0 one-shot) and bits 3:2 = prescale. Prescale code 0 decrements once per clock, code 1 once per 16 clocks, code 2 once per 256 clocks, and code 3 behaves like code 0.
- R4: In periodic mode a decrement step taken while the count is 0 reloads the counter from the reload register. A period therefore lasts reload+1 decrement steps.
- R5: In one-shot mode the counter stops at 0 and the enable bit clears when the count reaches 0. If the count is already 0, the enable bit clears at the next decrement step.
- R6: The interrupt output rises on the decrement step that takes the count from 1 to 0. It stays high until it is cleared.
- R7: A write of any data to the clear address (3) drops the interrupt on the next cycle. If an expiry happens in the same cycle, the expiry wins. Reading address 3 returns the interrupt in bit 0.
- R8: While enable is 0, the counter and the prescaler hold their values.
- R9: After reset the reload register, counter, control register and interrupt all read 0.
- R10: Reading address 1 returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Word address: 0 reload, 1 count, 2 control, 3 clear/status |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps every prescale code, both modes and several reload values, including 0 and 1, and checks the count, enable and interrupt after every clock. A timer with an off-by-one period, with code 3 mapped to the wrong division, or that reloads on reaching 0 instead of one step later would show up as a wrong count. A reload of 0 exposes any design that raises a false interrupt or never stops in one-shot mode. A reload write in the middle of a prescale period shows whether the prescaler restarts. An over-wide reload write and a long pause while disabled show whether either one disturbs the state.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_we,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic             irq
);

  localparam logic [1:0] A_RELOAD = 2'd0;
  localparam logic [1:0] A_COUNT  = 2'd1;
  localparam logic [1:0] A_CTRL   = 2'd2;
  localparam logic [1:0] A_CLEAR  = 2'd3;

  logic [CNT_W-1:0] reload_q, cnt_q;
  logic [PRE_W-1:0] pre_q, pre_top;
  logic [1:0]       psel_q;
  logic             en_q, per_q, irq_q;

  wire reload_wr = reg_we && reg_addr == A_RELOAD;
  wire reload_ok = reload_wr && reg_wdata[BUS_W-1:CNT_W] == '0;
  wire ctrl_wr   = reg_we && reg_addr == A_CTRL;
  wire clear_wr  = reg_we && reg_addr == A_CLEAR;

  always_comb begin
    case (psel_q)
      2'b01:   pre_top = PRE_W'(15);
      2'b10:   pre_top = PRE_W'(255);
      default: pre_top = '0;
    endcase
  end

  wire step    = en_q && pre_q == pre_top;
  wire expire  = step && !reload_ok && cnt_q == CNT_W'(1);
  wire os_halt = step && !reload_ok && !per_q && cnt_q <= CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      pre_q    <= '0;
    end else if (reload_ok) begin
      reload_q <= reg_wdata[CNT_W-1:0];
      cnt_q    <= reg_wdata[CNT_W-1:0];
      pre_q    <= '0;
    end else if (step) begin
      pre_q <= '0;
      if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
      else if (per_q)   cnt_q <= reload_q;
    end else if (en_q) begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      psel_q <= 2'b00;
    end else if (ctrl_wr) begin
      en_q   <= reg_wdata[0];
      per_q  <= reg_wdata[1];
      psel_q <= reg_wdata[3:2];
    end else if (os_halt) begin
      en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (expire)   irq_q <= 1'b1;
    else if (clear_wr) irq_q <= 1'b0;
  end

  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RELOAD: reg_rdata[CNT_W-1:0] = reload_q;
      A_COUNT:  reg_rdata[CNT_W-1:0] = cnt_q;
      A_CTRL:   reg_rdata[3:0]       = {psel_q, per_q, en_q};
      default:  reg_rdata[0]         = irq_q;
    endcase
  end

  assert_reject_wide_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_wr && reg_wdata[BUS_W-1:CNT_W] != '0) |=> $stable(reload_q));

  assert_reload_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ok |=> (cnt_q == $past(reg_wdata[CNT_W-1:0]) && pre_q == '0));

  assert_periodic_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && per_q && cnt_q == '0 && !reload_ok) |=> cnt_q == $past(reload_q));

  assert_oneshot_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !per_q && cnt_q == CNT_W'(1) && !reload_ok && !ctrl_wr) |=> (!en_q && cnt_q == '0));

  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == CNT_W'(1) && !reload_ok) |=> irq);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clear_wr) |=> irq);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && !(step && cnt_q == CNT_W'(1) && !reload_ok)) |=> !irq);

  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reload_ok) |=> ($stable(cnt_q) && $stable(pre_q)));

endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic run(int code, int per, int ld);
    int div, ticks, cnt, en_e, irq_e, v, steps;
    div = (code == 1) ? 16 : (code == 2) ? 256 : 1;
    wr(2'd2, 32'd0);
    wr(2'd0, 32'(ld));
    wr(2'd3, 32'hdead);
    chk("R7 clear before run", int'(irq), 0);
    wr(2'd2, 32'((code << 2) | (per << 1) | 1));
    steps = 2 * (ld + 1) * div + 3;
    for (int n = 1; n <= steps; n++) begin
      @(negedge clk);
      ticks = n / div;
      if (per != 0) begin
        cnt = ld - (ticks % (ld + 1));
        en_e = 1;
        irq_e = (ld >= 1 && ticks >= ld) ? 1 : 0;
      end else begin
        cnt = (ld > ticks) ? ld - ticks : 0;
        en_e = (ticks < ((ld > 0) ? ld : 1)) ? 1 : 0;
        irq_e = (ld >= 1 && ticks >= ld) ? 1 : 0;
      end
      rd(2'd1, v);
      chk(per ? "R4 R10 periodic count" : "R5 R10 one-shot count", v, cnt);
      rd(2'd2, v);
      chk("R3 R5 enable bit", v & 1, en_e);
      chk("R6 irq level", int'(irq), irq_e);
    end
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R9 reset register", v, 0);
    end
    chk("R9 reset irq", int'(irq), 0);

    wr(2'd2, 32'hE);
    rd(2'd2, v);
    chk("R3 control readback", v, 32'hE);

    for (int code = 0; code < 4; code++)
      for (int per = 0; per < 2; per++) begin
        run(code, per, 0);
        run(code, per, 1);
        run(code, per, 3);
      end
    run(0, 1, 200);
    run(1, 0, 5);

    wr(2'd2, 32'd0);
    wr(2'd0, 32'd77);
    wr(2'd0, 32'h0001_0005);
    rd(2'd0, v);
    chk("R1 wide reload keeps reload", v, 77);
    rd(2'd1, v);
    chk("R1 wide reload keeps count", v, 77);

    wr(2'd2, 32'(4 | 2 | 1));
    repeat (20) @(negedge clk);
    wr(2'd2, 32'd6);
    rd(2'd1, v);
    repeat (300) @(negedge clk);
    begin
      int v2;
      rd(2'd1, v2);
      chk("R8 disabled count holds", v2, v);
    end

    wr(2'd0, 32'd100);
    wr(2'd2, 32'(4 | 2 | 1));
    repeat (7) @(negedge clk);
    wr(2'd0, 32'd50);
    repeat (15) @(negedge clk);
    rd(2'd1, v);
    chk("R2 prescaler restarted, no step yet", v, 50);
    @(negedge clk);
    rd(2'd1, v);
    chk("R2 first step one period after write", v, 49);

    wr(2'd2, 32'd0);
    wr(2'd0, 32'd1);
    wr(2'd2, 32'd1);
    @(negedge clk);
    chk("R6 irq after 1 to 0", int'(irq), 1);
    rd(2'd3, v);
    chk("R7 status bit reads irq", v, 1);
    wr(2'd3, 32'd0);
    chk("R7 clear with zero data", int'(irq), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule